// File: doc/BRIEF.md
# Display RAM Host Address Generator

This block produces the host-side write address for a one-bit-per-pixel display memory. The memory holds a set of byte-wide graphics pages, each with a fixed number of columns, plus one extra icon page that sits after the graphics data. The host first loads a page and a column with two address commands. It then streams data bytes. Each byte becomes one memory write at the current address, and the address advances automatically afterwards.

Three mode bits shape the advance and the data. The wrap bit makes the column return to zero at the end of a graphics page, with the page stepping to its neighbour. The direction bit chooses whether that step goes up or down, and the page count wraps at both edges of the graphics area. The bit-order bit selects whether the byte is stored as given or with its bits reversed.

The icon page never wraps, whatever the mode says. On the icon page, and on any page when wrap is off, the column climbs to one past the last column and parks there. Further writes are then dropped until the host loads a new address. An optional output register, chosen by a parameter, retimes the memory-side outputs by one cycle.

Top module: `dram_host_addr`

## Requirements
- R1: Reset sets the page and column to 0 and clears all three mode bits. A write issued directly after reset therefore goes to page 0, column 0, with wrap off and the byte bit-reversed.
- R2: A set-page command loads its value into the page address. A value greater than NUM_PAGES (the icon page index) is clamped to NUM_PAGES.
- R3: A set-column command loads its value into the column address. A value greater than NUM_COLS-1 is clamped to NUM_COLS-1.
- R4: A write strobe taken while the column is below NUM_COLS raises mem_we_o, with the page and column in effect before the advance. With OUT_REG=1 the outputs show this one cycle after the strobe; with OUT_REG=0 they show it in the same cycle.
- R5: With wrap off, each write increments the column and leaves the page unchanged. The column stops at NUM_COLS.
- R6: While the column equals NUM_COLS, write strobes leave mem_we_o low and leave the page and column unchanged until an address command loads a new value.
- R7: With wrap on, direction bit 0 and a graphics page (below NUM_PAGES), a write at column NUM_COLS-1 sets the column to 0 and raises the page by one. Page NUM_PAGES-1 goes to page 0.
- R8: With wrap on, direction bit 1 and a graphics page, a write at column NUM_COLS-1 sets the column to 0 and lowers the page by one. Page 0 goes to page NUM_PAGES-1.
- R9: On the icon page (page NUM_PAGES), the page never changes on a write and the column saturates at NUM_COLS, regardless of the wrap bit.
- R10: With the bit-order bit at 1 the byte is stored unchanged. With it at 0, output bit i equals input bit DATA_W-1-i.
- R11: If a set-page or set-column command arrives in the same cycle as a write, the write still happens at the old address. The auto-advance for that cycle is cancelled: commanded fields take the command value and the other field keeps its old value.
- R12: A mode load (cfg_ld_i) takes effect from the next cycle. A write in the same cycle as the load uses the previous mode bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_page_i | input | 1 | Load page address command |
| page_val_i | input | PW | Page value for set_page_i |
| set_col_i | input | 1 | Load column address command |
| col_val_i | input | CW | Column value for set_col_i |
| cfg_ld_i | input | 1 | Load mode bits |
| cfg_wrap_i | input | 1 | Wrap mode bit |
| cfg_dec_i | input | 1 | Page direction bit, 1 = decrement |
| cfg_msb_i | input | 1 | Bit order, 1 = byte stored unchanged |
| wr_i | input | 1 | Data write strobe |
| wr_data_i | input | DATA_W | Data byte |
| mem_we_o | output | 1 | Memory write enable |
| mem_page_o | output | PW | Memory page address |
| mem_col_o | output | CW | Memory column address |
| mem_data_o | output | DATA_W | Bit-ordered data byte |

## Verification
The bench builds the block with NUM_COLS=5, NUM_PAGES=4 and OUT_REG=1. With these values, both address inputs are three bits wide. Every page and column code, including each value that must be clamped, can then be loaded under all eight mode combinations. Each load is followed by enough writes to cross the end of a page, to wrap at both edges of the graphics area, and to saturate and park on the icon page. All of this fits in a few thousand cycles.

// File: rtl/dha_pkg.sv
package dha_pkg;

   typedef struct packed {
      logic wrap;
      logic dec;
      logic msb;
   } dha_mode_t;

   typedef enum logic [1:0] {
      ADV_HOLD = 2'd0,
      ADV_STEP = 2'd1,
      ADV_WRAP = 2'd2
   } dha_adv_e;

endpackage

// File: rtl/dha_col_next.sv
module dha_col_next
   import dha_pkg::*;
#(
   parameter int NUM_COLS = 102,
   parameter int CW       = $clog2(NUM_COLS + 1)
) (
   input  logic [CW-1:0] col_q,
   input  logic          wrap_ok,
   output dha_adv_e      adv,
   output logic [CW-1:0] col_nxt,
   output logic          room
);
   localparam logic [CW-1:0] END_COL  = CW'(NUM_COLS);
   localparam logic [CW-1:0] LAST_COL = CW'(NUM_COLS - 1);

   logic last;

   assign room = col_q < END_COL;
   assign last = col_q == LAST_COL;

   always_comb begin
      if (!room)
         adv = ADV_HOLD;
      else if (wrap_ok && last)
         adv = ADV_WRAP;
      else
         adv = ADV_STEP;
   end

   always_comb begin
      unique case (adv)
         ADV_STEP: col_nxt = col_q + CW'(1);
         ADV_WRAP: col_nxt = '0;
         default:  col_nxt = col_q;
      endcase
   end

endmodule

// File: rtl/dha_page_next.sv
module dha_page_next #(
   parameter int NUM_PAGES = 8,
   parameter int PW        = $clog2(NUM_PAGES + 1)
) (
   input  logic [PW-1:0] page_q,
   input  logic          dec,
   output logic [PW-1:0] page_nxt
);
   localparam logic [PW-1:0] LAST_PG = PW'(NUM_PAGES - 1);

   always_comb begin
      if (dec)
         page_nxt = (page_q == '0) ? LAST_PG : page_q - PW'(1);
      else
         page_nxt = (page_q == LAST_PG) ? '0 : page_q + PW'(1);
   end

endmodule

// File: rtl/dha_byte_order.sv
module dha_byte_order #(
   parameter int DATA_W = 8
) (
   input  logic              msb_first,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   logic [DATA_W-1:0] flipped;

   for (genvar i = 0; i < DATA_W; i++) begin : g_flip
      assign flipped[i] = din[DATA_W-1-i];
   end

   assign dout = msb_first ? din : flipped;

endmodule

// File: rtl/dram_host_addr.sv
module dram_host_addr
   import dha_pkg::*;
#(
   parameter int NUM_COLS  = 102,
   parameter int NUM_PAGES = 8,
   parameter int DATA_W    = 8,
   parameter bit OUT_REG   = 1'b0,
   localparam int CW       = $clog2(NUM_COLS + 1),
   localparam int PW       = $clog2(NUM_PAGES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_page_i,
   input  logic [PW-1:0]     page_val_i,
   input  logic              set_col_i,
   input  logic [CW-1:0]     col_val_i,
   input  logic              cfg_ld_i,
   input  logic              cfg_wrap_i,
   input  logic              cfg_dec_i,
   input  logic              cfg_msb_i,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic              mem_we_o,
   output logic [PW-1:0]     mem_page_o,
   output logic [CW-1:0]     mem_col_o,
   output logic [DATA_W-1:0] mem_data_o
);
   localparam logic [PW-1:0] ICON_PG  = PW'(NUM_PAGES);
   localparam logic [CW-1:0] LAST_COL = CW'(NUM_COLS - 1);

   if (NUM_COLS < 2) begin : g_bad_cols
      $error("dram_host_addr: NUM_COLS must be at least 2");
   end
   if (NUM_PAGES < 2) begin : g_bad_pages
      $error("dram_host_addr: NUM_PAGES must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("dram_host_addr: DATA_W must be at least 1");
   end

   dha_mode_t         mode_q;
   logic [PW-1:0]     page_q;
   logic [PW-1:0]     page_nxt;
   logic [PW-1:0]     page_ld;
   logic [CW-1:0]     col_q;
   logic [CW-1:0]     col_nxt;
   logic [CW-1:0]     col_ld;
   dha_adv_e          adv;
   logic              room;
   logic              on_icon;
   logic              cmd_any;
   logic              we_now;
   logic              step_ok;
   logic [DATA_W-1:0] data_ord;

   assign on_icon = page_q == ICON_PG;
   assign cmd_any = set_page_i | set_col_i;
   assign we_now  = wr_i & room;
   assign step_ok = we_now & ~cmd_any;
   assign page_ld = (page_val_i > ICON_PG) ? ICON_PG : page_val_i;
   assign col_ld  = (col_val_i > LAST_COL) ? LAST_COL : col_val_i;

   dha_col_next #(
      .NUM_COLS (NUM_COLS),
      .CW       (CW)
   ) u_col (
      .col_q   (col_q),
      .wrap_ok (mode_q.wrap & ~on_icon),
      .adv     (adv),
      .col_nxt (col_nxt),
      .room    (room)
   );

   dha_page_next #(
      .NUM_PAGES (NUM_PAGES),
      .PW        (PW)
   ) u_page (
      .page_q   (page_q),
      .dec      (mode_q.dec),
      .page_nxt (page_nxt)
   );

   dha_byte_order #(
      .DATA_W (DATA_W)
   ) u_order (
      .msb_first (mode_q.msb),
      .din       (wr_data_i),
      .dout      (data_ord)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         mode_q <= '0;
      else if (cfg_ld_i)
         mode_q <= '{wrap: cfg_wrap_i, dec: cfg_dec_i, msb: cfg_msb_i};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         page_q <= '0;
         col_q  <= '0;
      end else begin
         if (set_page_i)
            page_q <= page_ld;
         else if (step_ok && adv == ADV_WRAP)
            page_q <= page_nxt;

         if (set_col_i)
            col_q <= col_ld;
         else if (step_ok)
            col_q <= col_nxt;
      end
   end

   if (OUT_REG) begin : g_oreg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            mem_we_o   <= 1'b0;
            mem_page_o <= '0;
            mem_col_o  <= '0;
            mem_data_o <= '0;
         end else begin
            mem_we_o <= we_now;
            if (wr_i) begin
               mem_page_o <= page_q;
               mem_col_o  <= col_q;
               mem_data_o <= data_ord;
            end
         end
      end
   end else begin : g_ocomb
      assign mem_we_o   = we_now;
      assign mem_page_o = page_q;
      assign mem_col_o  = col_q;
      assign mem_data_o = data_ord;
   end

endmodule

// File: rtl/dha_chk.sv
module dha_chk #(
   parameter int NUM_COLS  = 102,
   parameter int NUM_PAGES = 8,
   parameter bit OUT_REG   = 1'b0,
   parameter int CW        = $clog2(NUM_COLS + 1),
   parameter int PW        = $clog2(NUM_PAGES + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          set_page_i,
   input logic [PW-1:0] page_val_i,
   input logic          set_col_i,
   input logic [CW-1:0] col_val_i,
   input logic          wr_i,
   input logic          wrap_q,
   input logic [PW-1:0] page_q,
   input logic [CW-1:0] col_q,
   input logic          mem_we_o
);
   localparam logic [PW-1:0] ICON_PG  = PW'(NUM_PAGES);
   localparam logic [CW-1:0] END_COL  = CW'(NUM_COLS);
   localparam logic [CW-1:0] LAST_COL = CW'(NUM_COLS - 1);

   logic quiet;
   assign quiet = ~set_page_i & ~set_col_i;

   // R2
   page_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_page_i |=> page_q == (($past(page_val_i) > ICON_PG) ? ICON_PG : $past(page_val_i)));

   // R3
   col_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_col_i |=> col_q == (($past(col_val_i) > LAST_COL) ? LAST_COL : $past(col_val_i)));

   // R5
   addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (col_q <= END_COL) && (page_q <= ICON_PG));

   // R6
   parked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && quiet && col_q == END_COL) |=> (col_q == END_COL) && $stable(page_q));

   // R7
   wrap_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && quiet && wrap_q && page_q < ICON_PG && col_q == LAST_COL)
         |=> (col_q == '0) && (page_q != $past(page_q)) && (page_q < ICON_PG));

   // R9
   icon_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && quiet && page_q == ICON_PG && col_q < END_COL)
         |=> (page_q == ICON_PG) && (col_q == $past(col_q) + CW'(1)));

   // R11
   cmd_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && set_page_i && !set_col_i) |=> $stable(col_q));

   // R4
   if (OUT_REG) begin : g_lat1
      we_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
         mem_we_o |-> $past(wr_i));
   end else begin : g_lat0
      we_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
         mem_we_o |-> wr_i);
   end

endmodule

bind dram_host_addr dha_chk #(
   .NUM_COLS  (NUM_COLS),
   .NUM_PAGES (NUM_PAGES),
   .OUT_REG   (OUT_REG)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .set_page_i (set_page_i),
   .page_val_i (page_val_i),
   .set_col_i  (set_col_i),
   .col_val_i  (col_val_i),
   .wr_i       (wr_i),
   .wrap_q     (mode_q.wrap),
   .page_q     (page_q),
   .col_q      (col_q),
   .mem_we_o   (mem_we_o)
);

// File: tb/dram_host_addr_tb.sv
`timescale 1ns/1ps
module dram_host_addr_tb;
   localparam int NC = 5;
   localparam int NP = 4;
   localparam int DW = 8;
   localparam int PW = $clog2(NP + 1);
   localparam int CW = $clog2(NC + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          set_page_i = 1'b0;
   logic [PW-1:0] page_val_i = '0;
   logic          set_col_i = 1'b0;
   logic [CW-1:0] col_val_i = '0;
   logic          cfg_ld_i = 1'b0;
   logic          cfg_wrap_i = 1'b0;
   logic          cfg_dec_i = 1'b0;
   logic          cfg_msb_i = 1'b0;
   logic          wr_i = 1'b0;
   logic [DW-1:0] wr_data_i = '0;
   logic          mem_we_o;
   logic [PW-1:0] mem_page_o;
   logic [CW-1:0] mem_col_o;
   logic [DW-1:0] mem_data_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   int mpage, mcol;
   bit mwrap, mdec, mmsb;

   always #2.5 clk = ~clk;

   dram_host_addr #(
      .NUM_COLS  (NC),
      .NUM_PAGES (NP),
      .DATA_W    (DW),
      .OUT_REG   (1'b1)
   ) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_page_i (set_page_i),
      .page_val_i (page_val_i),
      .set_col_i  (set_col_i),
      .col_val_i  (col_val_i),
      .cfg_ld_i   (cfg_ld_i),
      .cfg_wrap_i (cfg_wrap_i),
      .cfg_dec_i  (cfg_dec_i),
      .cfg_msb_i  (cfg_msb_i),
      .wr_i       (wr_i),
      .wr_data_i  (wr_data_i),
      .mem_we_o   (mem_we_o),
      .mem_page_o (mem_page_o),
      .mem_col_o  (mem_col_o),
      .mem_data_o (mem_data_o)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] flip(input logic [DW-1:0] d);
      logic [DW-1:0] r;
      for (int i = 0; i < DW; i++) r[i] = d[DW-1-i];
      return r;
   endfunction

   function automatic string state_tag();
      if (mcol >= NC) return "R6";
      if (mpage == NP) return "R9";
      if (mwrap && mcol == NC - 1) return mdec ? "R8" : "R7";
      if (!mwrap) return "R5";
      return "R4";
   endfunction

   task automatic model_adv();
      if (mcol < NC) begin
         if (mwrap && mpage < NP && mcol == NC - 1) begin
            mcol = 0;
            if (mdec) mpage = (mpage == 0) ? NP - 1 : mpage - 1;
            else      mpage = (mpage == NP - 1) ? 0 : mpage + 1;
         end else begin
            mcol++;
         end
      end
   endtask

   // one write; outputs are registered, so they are read at the following negedge
   task automatic do_wr(input logic [DW-1:0] d, input bit first);
      bit ewe;
      int ep, ec;
      logic [DW-1:0] ed;
      string tg;
      tg  = state_tag();
      ewe = (mcol < NC);
      ep  = mpage;
      ec  = mcol;
      ed  = mmsb ? d : flip(d);
      wr_i = 1'b1;
      wr_data_i = d;
      @(negedge clk);
      wr_i = 1'b0;
      chk(tg, "write enable", mem_we_o, ewe);
      if (ewe) begin
         chk(first ? "R2" : tg, "page", mem_page_o, ep);
         chk(first ? "R3" : tg, "column", mem_col_o, ec);
         chk("R10", "data", mem_data_o, ed);
      end
      model_adv();
   endtask

   task automatic load_addr(input int p, input int c);
      set_page_i = 1'b1;
      page_val_i = PW'(p);
      set_col_i  = 1'b1;
      col_val_i  = CW'(c);
      @(negedge clk);
      set_page_i = 1'b0;
      set_col_i  = 1'b0;
      mpage = (p > NP) ? NP : p;
      mcol  = (c > NC - 1) ? NC - 1 : c;
   endtask

   task automatic load_cfg(input bit w, input bit dn, input bit m);
      cfg_ld_i   = 1'b1;
      cfg_wrap_i = w;
      cfg_dec_i  = dn;
      cfg_msb_i  = m;
      @(negedge clk);
      cfg_ld_i = 1'b0;
      mwrap = w;
      mdec  = dn;
      mmsb  = m;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      mpage = 0; mcol = 0; mwrap = 0; mdec = 0; mmsb = 0;
      repeat (3) @(negedge clk);
      // R1: idle outputs while in reset
      chk("R1", "write enable in reset", mem_we_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "write enable after reset", mem_we_o, 0);

      // R4: the registered output is still low before the clock edge that takes the write
      wr_i = 1'b1;
      wr_data_i = 8'h01;
      #1;
      chk("R4", "enable before edge", mem_we_o, 0);
      wr_i = 1'b0;
      // R1: reset state gives page 0, column 0, reversed byte, no wrap
      do_wr(8'h01, 1'b0);
      chk("R1", "data reversed after reset", mem_data_o, 8'h80);
      for (int k = 0; k < NC + 1; k++) do_wr(DW'(8'h13 + 29 * k), 1'b0);
      chk("R1", "page stays 0 with wrap off", mpage, 0);

      // exhaustive sweep over modes, page codes and column codes
      for (int m = 0; m < 8; m++) begin
         load_cfg(m[0], m[1], m[2]);
         for (int p = 0; p < (1 << PW); p++) begin
            for (int c = 0; c < (1 << CW); c++) begin
               load_addr(p, c);
               for (int k = 0; k < NC + 3; k++)
                  do_wr(DW'(37 * p + 11 * c + 5 * k + m), k == 0);
            end
         end
      end

      // R11: set-page with a write, the write uses the old address, column not advanced
      load_cfg(1'b0, 1'b0, 1'b1);
      load_addr(1, 2);
      set_page_i = 1'b1;
      page_val_i = PW'(3);
      wr_i = 1'b1;
      wr_data_i = 8'h5A;
      @(negedge clk);
      set_page_i = 1'b0;
      wr_i = 1'b0;
      chk("R11", "write enable", mem_we_o, 1);
      chk("R11", "old page", mem_page_o, 1);
      chk("R11", "old column", mem_col_o, 2);
      mpage = 3;
      do_wr(8'h11, 1'b0);
      chk("R11", "column kept after load", mem_col_o, 2);
      chk("R11", "page loaded", mem_page_o, 3);

      // R11: set-column with a write on the last column, wrap on: page kept
      load_cfg(1'b1, 1'b0, 1'b1);
      load_addr(2, NC - 1);
      set_col_i = 1'b1;
      col_val_i = CW'(1);
      wr_i = 1'b1;
      wr_data_i = 8'hC3;
      @(negedge clk);
      set_col_i = 1'b0;
      wr_i = 1'b0;
      chk("R11", "old column", mem_col_o, NC - 1);
      mcol = 1;
      do_wr(8'h22, 1'b0);
      chk("R11", "page not stepped", mem_page_o, 2);
      chk("R11", "column loaded", mem_col_o, 1);

      // R6: parked column released by a new column load
      load_cfg(1'b0, 1'b0, 1'b1);
      load_addr(0, NC - 1);
      do_wr(8'h01, 1'b0);
      do_wr(8'h02, 1'b0);
      chk("R6", "parked enable", mem_we_o, 0);
      load_addr(0, 0);
      do_wr(8'h03, 1'b0);
      chk("R6", "released enable", mem_we_o, 1);

      // R12: mode load in the same cycle as a write uses the old bit order
      load_cfg(1'b0, 1'b0, 1'b1);
      load_addr(1, 0);
      cfg_ld_i = 1'b1;
      cfg_msb_i = 1'b0;
      wr_i = 1'b1;
      wr_data_i = 8'h0F;
      @(negedge clk);
      cfg_ld_i = 1'b0;
      wr_i = 1'b0;
      chk("R12", "old order in load cycle", mem_data_o, 8'h0F);
      mmsb = 1'b0;
      mcol = 1;
      do_wr(8'h0F, 1'b0);
      chk("R12", "new order after load", mem_data_o, 8'hF0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule